// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns single host requests into the multi-cycle bus traffic that a byte-wide parallel NOR flash needs. The host asks for a read, a byte program, a sector erase, a chip erase, a device identification, or a copy of one whole sector from a byte stream. The sequencer drives the flash address, data, chip-enable, write-enable and output-enable lines. It writes the unlock and command bytes, then reads the device back until the operation has finished. Completion is found by data polling, not by a ready/busy pin. The sequencer then puts the device back into read mode and returns the result.

Before each program the destination byte is read first. When it already holds the requested value, the command writes are skipped. On an erased device this means an FFh byte is never written. The two unlock addresses, the identification unlock addresses, the sector size, the bus-cycle lengths and the copy length are all parameters. This lets the same state machine serve flash parts with other address conventions.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation codes on `req_op` are 0 read, 1 program, 2 sector erase, 3 chip erase, 4 identify and 5 block copy. A request is taken when `req_valid` and `req_ready` are both high, and `busy` is high in the next cycle. Codes 6 and 7 are ignored. After reset `busy` is low and `req_ready` is high.
- R2: A program first reads the target byte. If the byte differs, the block writes AAh to UNLOCK_A, 55h to UNLOCK_B, A0h to UNLOCK_A and then the data byte to the target. It then reads the target until the returned byte equals the data, and `rsp_data` holds that byte.
- R3: If the pre-read byte already equals the requested value, no command write is made. `done` still pulses, and `rsp_data` holds the value that was read.
- R4: A sector erase writes AAh@UNLOCK_A, 55h@UNLOCK_B, 80h@UNLOCK_A, AAh@UNLOCK_A, 55h@UNLOCK_B, then 30h to the request address with its low SEC_W bits cleared. It polls that sector base until FFh is read, and leaves other sectors untouched.
- R5: A chip erase uses the same first five writes as a sector erase, then writes 10h to UNLOCK_A. It polls BASE_ADDR until FFh is read.
- R6: Every operation except a read ends by writing F0h to BASE_ADDR before `done`.
- R7: Identify writes AAh@ID_A, 55h@ID_B and 90h@ID_A, then reads BASE_ADDR. It writes F0h, unlocks again, reads BASE_ADDR+1 and writes F0h. `rsp_id[15:8]` holds the first byte read and `rsp_id[7:0]` holds the second.
- R8: Block copy takes BLOCK_BYTES bytes, one per `src_valid && src_ready`. It programs them to consecutive addresses starting at `req_addr`, each byte by the rules of R2 and R3.
- R9: A bus write holds `fl_ce_n` low with stable address and data for WR_CYC clocks. `fl_we_n` is low on every one of those clocks except the first and the last. A read holds `fl_oe_n` low for RD_CYC clocks. `fl_we_n` and `fl_oe_n` are never low together, and `fl_we_n` is low only while `fl_ce_n` is low.
- R10: While `busy` is high, `req_ready` is low and requests have no effect.
- R11: `done` is high for exactly one clock per operation, and `busy` is low in the following clock.
- R12: A read makes one bus read of `req_addr` and no bus write, and returns the byte on `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Target address or copy start address |
| req_data | input | 8 | Program data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Read, poll or pre-read result |
| rsp_id | output | 16 | Vendor byte (high) and device byte (low) |
| src_valid | input | 1 | Copy stream byte available |
| src_ready | output | 1 | Copy stream byte taken this clock |
| src_data | input | 8 | Copy stream byte |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for flash data |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
A wrong step index or a wrong address selector shows as a command write the flash does not recognise. The model device then never turns busy, or it stays in its unlock state. In either case the poll loop never ends and `done` never arrives, so the bench's bounded wait reports it within a few thousand clocks. A wrong pre-read comparison shows at once in the count of program commands seen on the bus. A missing reset write leaves the model in identify mode, and the next plain read returns an ID byte in place of memory content. A broken bus-cycle counter changes the width of the write-enable pulse, which the bus monitor reports on the same write.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_CHIP = 3'd3,
        OP_ID   = 3'd4,
        OP_COPY = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        AS_UA,
        AS_UB,
        AS_IA,
        AS_IB,
        AS_TGT,
        AS_SEC,
        AS_BASE
    } asel_e;

    typedef struct packed {
        asel_e      asel;
        logic       host_data;
        logic [7:0] data;
    } step_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_ACT,
        B_GAP
    } bus_st_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_FETCH,
        C_CHECK,
        C_CMD,
        C_POLL,
        C_IDRD,
        C_RESET,
        C_DONE
    } ctrl_st_e;

    localparam logic [7:0] CB_UNLK1 = 8'hAA;
    localparam logic [7:0] CB_UNLK2 = 8'h55;
    localparam logic [7:0] CB_PROG  = 8'hA0;
    localparam logic [7:0] CB_ERASE = 8'h80;
    localparam logic [7:0] CB_SECT  = 8'h30;
    localparam logic [7:0] CB_CHIP  = 8'h10;
    localparam logic [7:0] CB_ID    = 8'h90;
    localparam logic [7:0] CB_RST   = 8'hF0;
    localparam logic [7:0] ERASED   = 8'hFF;

    function automatic logic op_valid(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic step_t mk(input asel_e a, input logic hd, input logic [7:0] d);
        step_t s;
        s.asel      = a;
        s.host_data = hd;
        s.data      = d;
        return s;
    endfunction

    function automatic logic [2:0] seq_len(input op_e op);
        case (op)
            OP_PROG, OP_COPY: return 3'd4;
            OP_SECT, OP_CHIP: return 3'd6;
            OP_ID:            return 3'd3;
            default:          return 3'd1;
        endcase
    endfunction

    function automatic step_t seq_step(input op_e op, input logic [2:0] idx);
        step_t s;
        s = mk(AS_BASE, 1'b0, CB_RST);
        case (op)
            OP_PROG, OP_COPY: begin
                case (idx)
                    3'd0:    s = mk(AS_UA, 1'b0, CB_UNLK1);
                    3'd1:    s = mk(AS_UB, 1'b0, CB_UNLK2);
                    3'd2:    s = mk(AS_UA, 1'b0, CB_PROG);
                    default: s = mk(AS_TGT, 1'b1, 8'h00);
                endcase
            end
            OP_SECT, OP_CHIP: begin
                case (idx)
                    3'd0, 3'd3: s = mk(AS_UA, 1'b0, CB_UNLK1);
                    3'd1, 3'd4: s = mk(AS_UB, 1'b0, CB_UNLK2);
                    3'd2:       s = mk(AS_UA, 1'b0, CB_ERASE);
                    default:    s = (op == OP_SECT) ? mk(AS_SEC, 1'b0, CB_SECT)
                                                    : mk(AS_UA, 1'b0, CB_CHIP);
                endcase
            end
            OP_ID: begin
                case (idx)
                    3'd0:    s = mk(AS_IA, 1'b0, CB_UNLK1);
                    3'd1:    s = mk(AS_IB, 1'b0, CB_UNLK2);
                    default: s = mk(AS_IA, 1'b0, CB_ID);
                endcase
            end
            default: s = mk(AS_BASE, 1'b0, CB_RST);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int WR_CYC = 4,
    parameter int RD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              done,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int MAXC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WL = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] RL = CW'(RD_CYC - 1);

    bus_st_e           st;
    logic [CW-1:0]     cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;
    logic              done_q;
    logic [CW-1:0]     last;

    assign last = wr_q ? WL : RL;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                B_IDLE: if (start) begin
                    wr_q    <= wr;
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    cnt     <= '0;
                    st      <= B_ACT;
                end
                B_ACT: begin
                    if (cnt == last) begin
                        if (!wr_q) rdata_q <= fl_dq_in;
                        st <= B_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st     <= B_IDLE;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    assign fl_ce_n   = (st != B_ACT);
    assign fl_oe_n   = !((st == B_ACT) && !wr_q);
    assign fl_we_n   = !((st == B_ACT) && wr_q && (cnt != '0) && (cnt != last));
    assign fl_dq_oe  = (st == B_ACT) && wr_q;
    assign fl_addr   = addr_q;
    assign fl_dq_out = wdata_q;
    assign done      = done_q;
    assign rdata     = rdata_q;

    p_we_in_ce_r9: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_dq_oe))
        else $error("write strobe outside a selected write cycle");

    p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n))
        else $error("write and output enable both active");

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)))
        else $error("address or data moved inside a bus cycle");

    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_ce_n) |=> fl_ce_n)
        else $error("no idle clock between bus cycles");

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int          ADDR_W      = 22,
    parameter int          SEC_W       = 16,
    parameter int          BLOCK_BYTES = 65536,
    parameter logic [15:0] UNLOCK_A    = 16'h0555,
    parameter logic [15:0] UNLOCK_B    = 16'h02AA,
    parameter logic [15:0] ID_A        = 16'h5555,
    parameter logic [15:0] ID_B        = 16'hAAAA,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rsp_data,
    output logic [15:0]       rsp_id,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [7:0]        src_data,
    output logic              bus_start,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_done,
    input  logic [7:0]        bus_rdata
);
    localparam int CNT_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [CNT_W-1:0]  LAST_BYTE = CNT_W'(BLOCK_BYTES - 1);
    localparam logic [ADDR_W-1:0] SEC_MASK  = {ADDR_W{1'b1}} << SEC_W;
    localparam logic [ADDR_W-1:0] UA = ADDR_W'(UNLOCK_A);
    localparam logic [ADDR_W-1:0] UB = ADDR_W'(UNLOCK_B);
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(ID_A);
    localparam logic [ADDR_W-1:0] IB = ADDR_W'(ID_B);

    ctrl_st_e          st;
    op_e               op_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [7:0]        data_q;
    logic [7:0]        rdata_q;
    logic [7:0]        vendor_q;
    logic [15:0]       id_q;
    logic [2:0]        step_q;
    logic [1:0]        id_ph;
    logic [CNT_W-1:0]  byte_cnt;
    logic              pending;

    step_t             cur;
    logic              on_bus;
    logic              last_step;
    logic              is_erase;
    logic [7:0]        poll_exp;
    logic [ADDR_W-1:0] sec_base;

    assign cur       = seq_step(op_q, step_q);
    assign last_step = (step_q == seq_len(op_q) - 3'd1);
    assign is_erase  = (op_q == OP_SECT) || (op_q == OP_CHIP);
    assign poll_exp  = is_erase ? ERASED : data_q;
    assign sec_base  = tgt_q & SEC_MASK;
    assign on_bus    = (st == C_CHECK) || (st == C_CMD) || (st == C_POLL) ||
                       (st == C_IDRD)  || (st == C_RESET);
    assign bus_start = on_bus && !pending;
    assign req_ready = (st == C_IDLE);
    assign busy      = (st != C_IDLE);
    assign done      = (st == C_DONE);
    assign src_ready = (st == C_FETCH);
    assign rsp_data  = rdata_q;
    assign rsp_id    = id_q;

    always_comb begin
        bus_wr    = 1'b0;
        bus_addr  = tgt_q;
        bus_wdata = CB_RST;
        case (st)
            C_CMD: begin
                bus_wr    = 1'b1;
                bus_wdata = cur.host_data ? data_q : cur.data;
                case (cur.asel)
                    AS_UA:   bus_addr = UA;
                    AS_UB:   bus_addr = UB;
                    AS_IA:   bus_addr = IA;
                    AS_IB:   bus_addr = IB;
                    AS_SEC:  bus_addr = sec_base;
                    AS_BASE: bus_addr = BASE_ADDR;
                    default: bus_addr = tgt_q;
                endcase
            end
            C_POLL: begin
                if (op_q == OP_SECT)      bus_addr = sec_base;
                else if (op_q == OP_CHIP) bus_addr = BASE_ADDR;
                else                      bus_addr = tgt_q;
            end
            C_IDRD:  bus_addr = BASE_ADDR + ADDR_W'(id_ph == 2'd2);
            C_RESET: begin
                bus_wr   = 1'b1;
                bus_addr = BASE_ADDR;
            end
            default: bus_addr = tgt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            op_q     <= OP_READ;
            tgt_q    <= '0;
            data_q   <= '0;
            rdata_q  <= '0;
            vendor_q <= '0;
            id_q     <= '0;
            step_q   <= '0;
            id_ph    <= '0;
            byte_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            if (bus_start) pending <= 1'b1;
            if (bus_done)  pending <= 1'b0;
            case (st)
                C_IDLE: if (req_valid && op_valid(req_op)) begin
                    op_q     <= op_e'(req_op);
                    tgt_q    <= req_addr;
                    data_q   <= req_data;
                    step_q   <= '0;
                    id_ph    <= '0;
                    byte_cnt <= '0;
                    case (op_e'(req_op))
                        OP_READ, OP_PROG: st <= C_CHECK;
                        OP_COPY:          st <= C_FETCH;
                        default:          st <= C_CMD;
                    endcase
                end
                C_FETCH: if (src_valid) begin
                    data_q <= src_data;
                    st     <= C_CHECK;
                end
                C_CHECK: if (bus_done) begin
                    rdata_q <= bus_rdata;
                    if (op_q == OP_READ) begin
                        st <= C_DONE;
                    end else if (bus_rdata != data_q) begin
                        step_q <= '0;
                        st     <= C_CMD;
                    end else if (op_q == OP_COPY && byte_cnt != LAST_BYTE) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        tgt_q    <= tgt_q + 1'b1;
                        st       <= C_FETCH;
                    end else begin
                        st <= C_RESET;
                    end
                end
                C_CMD: if (bus_done) begin
                    if (last_step) begin
                        step_q <= '0;
                        st     <= (op_q == OP_ID) ? C_IDRD : C_POLL;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                C_POLL: if (bus_done && bus_rdata == poll_exp) begin
                    rdata_q <= bus_rdata;
                    if (op_q == OP_COPY && byte_cnt != LAST_BYTE) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        tgt_q    <= tgt_q + 1'b1;
                        st       <= C_FETCH;
                    end else begin
                        st <= C_RESET;
                    end
                end
                C_IDRD: if (bus_done) begin
                    rdata_q <= bus_rdata;
                    if (id_ph == 2'd0) begin
                        vendor_q <= bus_rdata;
                        id_ph    <= 2'd1;
                    end else begin
                        id_q <= {vendor_q, bus_rdata};
                    end
                    st <= C_RESET;
                end
                C_RESET: if (bus_done) begin
                    if (op_q == OP_ID && id_ph == 2'd1) begin
                        id_ph  <= 2'd2;
                        step_q <= '0;
                        st     <= C_CMD;
                    end else begin
                        st <= C_DONE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && op_valid(req_op)) |=> busy)
        else $error("valid request not taken");

    p_bad_op_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !op_valid(req_op)) |=> !busy)
        else $error("undefined operation code started work");

    p_prog_differs_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_start && st == C_CMD && cur.host_data) |-> (data_q != rdata_q))
        else $error("program issued for a byte that already matched");

    p_stream_copy_r8: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> (op_q == OP_COPY))
        else $error("stream byte taken outside block copy");

    p_busy_block_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready)
        else $error("ready while busy");

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy))
        else $error("done longer than one clock");

    p_reset_last_r6: assert property (@(posedge clk) disable iff (rst)
        (done && op_q != OP_READ) |-> $past(st == C_RESET))
        else $error("completion without read-mode write");

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int          ADDR_W      = 22,
    parameter int          SEC_W       = 16,
    parameter int          WR_CYC      = 4,
    parameter int          RD_CYC      = 3,
    parameter int          BLOCK_BYTES = 65536,
    parameter logic [15:0] UNLOCK_A    = 16'h0555,
    parameter logic [15:0] UNLOCK_B    = 16'h02AA,
    parameter logic [15:0] ID_A        = 16'h5555,
    parameter logic [15:0] ID_B        = 16'hAAAA,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rsp_data,
    output logic [15:0]       rsp_id,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [7:0]        src_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    logic              bus_start;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_done;
    logic [7:0]        bus_rdata;

    nor_seq_ctrl #(
        .ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLOCK_BYTES(BLOCK_BYTES),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .ID_A(ID_A), .ID_B(ID_B),
        .BASE_ADDR(BASE_ADDR)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_id(rsp_id),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .bus_start(bus_start), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
    );

    nor_bus_engine #(
        .ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
    ) u_bus (
        .clk(clk), .rst(rst),
        .start(bus_start), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .done(bus_done), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n)
    );

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    localparam int AW  = 16;
    localparam int SW  = 4;
    localparam int WRC = 4;
    localparam int RDC = 3;
    localparam int BLK = 16;
    localparam logic [7:0] VEND = 8'h3D;
    localparam logic [7:0] DEV  = 8'h7A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done;
    logic [7:0]    rsp_data;
    logic [15:0]   rsp_id;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [7:0]    src_data;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    nor_cmd_seq #(
        .ADDR_W(AW), .SEC_W(SW), .WR_CYC(WRC), .RD_CYC(RDC), .BLOCK_BYTES(BLK)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_id(rsp_id),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n)
    );

    // ---------------- flash device model ----------------
    logic [7:0]  mem [256];
    logic [2:0]  ucnt;
    logic        prog_arm, id_mode;
    logic [1:0]  busy_cnt;
    logic [7:0]  busy_val;
    logic        prev_we, prev_oe;
    int          n_writes, n_prog, n_ff, n_erase, n_reset, bus_err, we_run;
    logic [AW-1:0] last_waddr;
    logic [7:0]  last_wdata;
    logic [10:0] cmd_a;
    logic [7:0]  sidx;

    assign cmd_a    = fl_addr[10:0];
    assign fl_dq_in = id_mode ? (fl_addr[0] ? DEV : VEND)
                    : (busy_cnt != 0) ? ~busy_val : mem[fl_addr[7:0]];
    assign src_data = (sidx == 8'd5) ? 8'hFF : 8'(sidx * 7 + 3);

    always @(posedge clk) begin
        if (rst) sidx <= '0;
        else if (src_valid && src_ready) sidx <= sidx + 1'b1;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i);
            ucnt <= '0; prog_arm <= 1'b0; id_mode <= 1'b0;
            busy_cnt <= '0; busy_val <= '0;
            prev_we <= 1'b1; prev_oe <= 1'b1;
            n_writes <= 0; n_prog <= 0; n_ff <= 0; n_erase <= 0; n_reset <= 0;
            bus_err <= 0; we_run <= 0;
            last_waddr <= '0; last_wdata <= '0;
        end else begin
            prev_we <= fl_we_n;
            prev_oe <= fl_oe_n;
            if (!fl_we_n) we_run <= we_run + 1;
            if (!fl_we_n && !fl_oe_n) bus_err <= bus_err + 1;
            if (!fl_we_n && fl_ce_n) bus_err <= bus_err + 1;
            if (!prev_oe && fl_oe_n && busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
            if (!prev_we && fl_we_n) begin
                if (we_run != WRC - 2) bus_err <= bus_err + 1;
                we_run     <= 0;
                n_writes   <= n_writes + 1;
                last_waddr <= fl_addr;
                last_wdata <= fl_dq_out;
                if (prog_arm) begin
                    mem[fl_addr[7:0]] <= mem[fl_addr[7:0]] & fl_dq_out;
                    busy_val <= mem[fl_addr[7:0]] & fl_dq_out;
                    busy_cnt <= 2'd3;
                    prog_arm <= 1'b0;
                    n_prog   <= n_prog + 1;
                    if (fl_dq_out == 8'hFF) n_ff <= n_ff + 1;
                    ucnt <= '0;
                end else if (fl_dq_out == 8'hF0) begin
                    ucnt <= '0; id_mode <= 1'b0; n_reset <= n_reset + 1;
                end else begin
                    case (ucnt)
                        3'd0: ucnt <= (fl_dq_out == 8'hAA && cmd_a == 11'h555) ? 3'd1 : 3'd0;
                        3'd1: ucnt <= (fl_dq_out == 8'h55 && cmd_a == 11'h2AA) ? 3'd2 : 3'd0;
                        3'd2: begin
                            ucnt <= '0;
                            if (cmd_a == 11'h555) begin
                                if (fl_dq_out == 8'hA0) prog_arm <= 1'b1;
                                if (fl_dq_out == 8'h90) id_mode <= 1'b1;
                                if (fl_dq_out == 8'h80) ucnt <= 3'd3;
                            end
                        end
                        3'd3: ucnt <= (fl_dq_out == 8'hAA && cmd_a == 11'h555) ? 3'd4 : 3'd0;
                        3'd4: ucnt <= (fl_dq_out == 8'h55 && cmd_a == 11'h2AA) ? 3'd5 : 3'd0;
                        default: begin
                            ucnt <= '0;
                            if (fl_dq_out == 8'h30) begin
                                for (int i = 0; i < 16; i++)
                                    mem[{fl_addr[7:4], 4'(i)}] <= 8'hFF;
                                busy_val <= 8'hFF; busy_cnt <= 2'd3; n_erase <= n_erase + 1;
                            end else if (fl_dq_out == 8'h10 && cmd_a == 11'h555) begin
                                for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
                                busy_val <= 8'hFF; busy_cnt <= 2'd3; n_erase <= n_erase + 1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        int t;
        t = 0;
        while (!req_ready && t < 5000) begin @(negedge clk); t++; end
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (!done) chk("R11 done timeout", 0, 1);
        @(negedge clk);
        chk("R11 done single pulse, busy low", {done, busy}, 2'b00);
    endtask

    // {op, addr, data, expected rsp_data, expected program commands}
    localparam int NV = 14;
    localparam logic [42:0] VEC [NV] = '{
        {3'd0, 16'h0010, 8'h00, 8'h10, 8'd0},  // R12 read
        {3'd1, 16'h0010, 8'h00, 8'h00, 8'd1},  // R2 program
        {3'd0, 16'h0010, 8'h00, 8'h00, 8'd0},  // R2 readback
        {3'd1, 16'h0021, 8'h21, 8'h21, 8'd0},  // R3 skip
        {3'd1, 16'h0030, 8'h20, 8'h20, 8'd1},  // R2 program
        {3'd2, 16'h0013, 8'h00, 8'hFF, 8'd0},  // R4 sector erase
        {3'd0, 16'h0010, 8'h00, 8'hFF, 8'd0},  // R4
        {3'd0, 16'h001F, 8'h00, 8'hFF, 8'd0},  // R4
        {3'd0, 16'h0020, 8'h00, 8'h20, 8'd0},  // R4 other sector kept
        {3'd3, 16'h0000, 8'h00, 8'hFF, 8'd0},  // R5 chip erase
        {3'd0, 16'h0020, 8'h00, 8'hFF, 8'd0},  // R5
        {3'd0, 16'h00FF, 8'h00, 8'hFF, 8'd0},  // R5
        {3'd1, 16'h0055, 8'hF0, 8'hF0, 8'd1},  // R2 data equal to reset code
        {3'd1, 16'h0056, 8'hFF, 8'hFF, 8'd0}   // R3 erased byte
    };
    localparam string VREQ [NV] = '{"R12", "R2", "R2", "R3", "R2", "R4", "R4",
                                    "R4", "R4", "R5", "R5", "R5", "R2", "R3"};

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pw, ww, rr, ee;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset busy/ready", {busy, req_ready}, 2'b01);
        chk("R9 reset bus idle", {fl_ce_n, fl_we_n, fl_oe_n, done}, 4'b1110);

        for (int i = 0; i < NV; i++) begin
            pw = n_prog; ww = n_writes; ee = n_erase;
            run_op(VEC[i][42:40], VEC[i][39:24], VEC[i][23:16]);
            chk({VREQ[i], " rsp_data"}, rsp_data, VEC[i][15:8]);
            chk({VREQ[i], " program count"}, n_prog - pw, VEC[i][7:0]);
            if (VEC[i][42:40] == 3'd0)
                chk("R12 read makes no write", n_writes - ww, 0);
            else
                chk("R6 final write F0 at base", {last_wdata, last_waddr}, {8'hF0, 16'h0000});
            if (VEC[i][42:40] == 3'd2 || VEC[i][42:40] == 3'd3)
                chk("R4 R5 erase accepted by device", n_erase - ee, 1);
        end

        // R7 identify
        rr = n_reset;
        run_op(3'd4, 16'h0000, 8'h00);
        chk("R7 id bytes", rsp_id, {VEND, DEV});
        chk("R7 two read-mode writes", n_reset - rr, 2);
        run_op(3'd0, 16'h0001, 8'h00);
        chk("R7 device back in read mode", rsp_data, 8'hFF);

        // R1 undefined code ignored
        ww = n_writes;
        req_op = 3'd7; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 code 7 ignored", {busy, n_writes - ww}, {1'b0, 32'd0});

        // R10 request during busy ignored
        pw = n_prog;
        req_op = 3'd2; req_addr = 16'h0080; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 not ready while busy", {busy, req_ready}, 2'b10);
        req_op = 3'd1; req_addr = 16'h0090; req_data = 8'h00; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R10 no second operation", {busy, n_prog - pw}, {1'b0, 32'd0});
        run_op(3'd0, 16'h0090, 8'h00);
        chk("R10 ignored program left byte", rsp_data, 8'hFF);

        // R8 block copy
        pw = n_prog;
        src_valid = 1'b1;
        run_op(3'd5, 16'h0040, 8'h00);
        src_valid = 1'b0;
        chk("R8 programs issued", n_prog - pw, BLK - 1);
        chk("R3 FF never programmed", n_ff, 0);
        chk("R8 stream bytes consumed", sidx, BLK);
        for (int k = 0; k < BLK; k++) begin
            run_op(3'd0, 16'h0040 + 16'(k), 8'h00);
            chk("R8 copied byte", rsp_data, (k == 5) ? 8'hFF : 8'(k * 7 + 3));
        end

        chk("R9 bus timing violations", bus_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule